// File: doc/BRIEF.md
# Privilege-Tagged Translation Cache

This block is a direct-mapped cache of page translations. It sits in front of a slower translation path and answers read, write and read-modify-write lookups in a single clock. A lookup gives a linear address, an access size of 1, 2, 4 or 8 bytes, an access kind and the current privilege level (0 to 3). A lookup that finds a valid entry with the same linear page and the permission it needs returns the physical address, made of the entry's physical frame followed by the page offset. It also returns the entry's host page pointer followed by the same offset. Any other lookup is reported as a miss, and an outside slow path then handles the access.

Each entry holds two permission bits for every privilege level: one that allows reads and one that allows writes. A read-modify-write access is checked against the write bit only. The set index is taken from the last byte of the access, and the alignment of the access is part of the tag compare. A multi-byte access that is not aligned to its size therefore never matches, and neither does an access that runs off the end of a page. Both go to the slow path. Every write or read-modify-write hit sends a notification that carries the frame, so that code caches can drop stale lines.

Entries are written through a fill port and are all cleared by one invalidate input. Pages are 4 KiB, so the page offset is address bits [11:0].

Top module: `xlat_cache`

## Requirements
- R1: Every lookup request gets a response (`rsp_valid`) exactly one clock later. No response is raised in any cycle that does not follow a request.
- R2: On a hit, `rsp_paddr` is the entry frame concatenated with request address bits [11:0], and `rsp_host` is the entry host page concatenated with the same bits.
- R3: A read (`req_kind` = 0) hits only if permission bit p of the entry is set, where p is `req_cpl`.
- R4: Every nonzero `req_kind` is checked against write bit 4+p only: 1 = write, 2 = read-modify-write, 3 = treated as read-modify-write. If the read bit is set and the write bit is clear, the lookup misses.
- R5: After reset no entry is valid. A lookup to an empty entry misses, and so does a lookup whose linear page differs from the entry tag.
- R6: `req_size` encodes the byte count as 2^code, so code 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8. An access whose address is not a multiple of its size misses. This includes an access that would cross the end of a page.
- R7: A lookup uses set ((address + size - 1) >> 12) mod ENTRIES. A fill uses set (`fill_lpage` mod ENTRIES) and replaces that entry, so a later fill of an aliasing page evicts the earlier one.
- R8: A hit with a nonzero kind raises `wnote_valid` in the response cycle, with `wnote_frame` equal to the entry frame. Reads and misses never raise it.
- R9: `inv_all` clears every entry in one cycle. If a fill arrives in the same cycle, the filled entry is valid afterwards.
- R10: A lookup issued in the same cycle as a fill to its set sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_laddr | input | LADDR_W | Linear address of the access |
| req_size | input | 2 | Access size code, 2^code bytes |
| req_kind | input | 2 | 0 read, 1 write, 2/3 read-modify-write |
| req_cpl | input | $clog2(NUM_PL) | Current privilege level |
| fill_valid | input | 1 | Write one entry |
| fill_lpage | input | LADDR_W-PAGE_BITS | Linear page number to install |
| fill_frame | input | FRAME_W | Physical frame for that page |
| fill_host | input | HPN_W | Host page pointer for that page |
| fill_perm | input | 2*NUM_PL | Read bits [NUM_PL-1:0], write bits above them |
| inv_all | input | 1 | Clear all entries |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_hit | output | 1 | Fast-path hit |
| rsp_paddr | output | FRAME_W+PAGE_BITS | Physical address on hit |
| rsp_host | output | HPN_W+PAGE_BITS | Host address on hit |
| wnote_valid | output | 1 | Write hit notification |
| wnote_frame | output | FRAME_W | Frame that was written |

## Verification
The bench builds the cache with ENTRIES = 4 and otherwise default widths. With only four sets, pages 0x12 and 0x16 alias into one set and pages 0x13 and 0x17 into another, so eviction, fill-versus-lookup collisions and cross-page indexing all occur with a handful of fills. Because pages 0x12 and 0x13 sit in adjacent sets, an 8-byte access at offset 0xFFC indexes the set of the following page. That exercises the misalignment miss against a valid neighbouring entry and not merely an empty set.

// File: rtl/xlat_cache_pkg.sv
`timescale 1ns/1ps
package xlat_cache_pkg;

   typedef enum logic [1:0] {
      ACC_READ    = 2'd0,
      ACC_WRITE   = 2'd1,
      ACC_RMW     = 2'd2,
      ACC_RMW_ALT = 2'd3
   } acc_kind_e;

   // Any kind other than a plain read is checked against the write bit.
   function automatic logic kind_needs_write(input logic [1:0] kind);
      return kind != ACC_READ;
   endfunction

   // Size code to (bytes - 1): 0->0, 1->1, 2->3, 3->7.
   function automatic logic [3:0] size_span(input logic [1:0] code);
      return (4'd1 << code) - 4'd1;
   endfunction

endpackage

// File: rtl/xlat_req_decode.sv
`timescale 1ns/1ps
module xlat_req_decode
   import xlat_cache_pkg::*;
#(
   parameter int LADDR_W   = 32,
   parameter int PAGE_BITS = 12,
   parameter int IDX_W     = 4,
   parameter int NUM_PL    = 4,
   localparam int LPN_W    = LADDR_W - PAGE_BITS,
   localparam int CPL_W    = $clog2(NUM_PL),
   localparam int PSEL_W   = $clog2(2 * NUM_PL)
) (
   input  logic [LADDR_W-1:0]   laddr,
   input  logic [1:0]           size,
   input  logic [1:0]           kind,
   input  logic [CPL_W-1:0]     cpl,
   output logic [IDX_W-1:0]     set_idx,
   output logic [LPN_W-1:0]     lpn,
   output logic [PAGE_BITS-1:0] offset,
   output logic                 misalign,
   output logic                 need_wr,
   output logic [PSEL_W-1:0]    perm_sel
);
   localparam logic [PAGE_BITS:0] PAGE_LAST = (PAGE_BITS+1)'((1 << PAGE_BITS) - 1);

   logic [3:0] span;
   logic       spills;

   assign span   = size_span(size);
   assign lpn    = laddr[LADDR_W-1:PAGE_BITS];
   assign offset = laddr[PAGE_BITS-1:0];

   // The last byte of the access picks the set, so a page-crossing access
   // looks in the set of the following page.
   assign spills  = ((PAGE_BITS+1)'(offset) + (PAGE_BITS+1)'(span)) > PAGE_LAST;
   assign set_idx = laddr[PAGE_BITS +: IDX_W] + IDX_W'(spills);

   // Low address bits covered by the span are part of the tag compare; a
   // stored tag has them at zero, so an unaligned access cannot match.
   assign misalign = |(laddr[2:0] & span[2:0]);

   assign need_wr  = kind_needs_write(kind);
   assign perm_sel = need_wr ? (PSEL_W'(NUM_PL) + PSEL_W'(cpl)) : PSEL_W'(cpl);

endmodule

// File: rtl/xlat_entry_store.sv
`timescale 1ns/1ps
module xlat_entry_store #(
   parameter int ENTRIES    = 16,
   parameter int LPN_W      = 20,
   parameter int FRAME_W    = 20,
   parameter int HPN_W      = 20,
   parameter int PERM_W     = 8,
   parameter bit STORE_HOST = 1'b1,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inv_all,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [LPN_W-1:0]   wr_lpn,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic [HPN_W-1:0]   wr_host,
   input  logic [PERM_W-1:0]  wr_perm,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic               rd_valid,
   output logic [LPN_W-1:0]   rd_lpn,
   output logic [FRAME_W-1:0] rd_frame,
   output logic [HPN_W-1:0]   rd_host,
   output logic [PERM_W-1:0]  rd_perm
);
   logic [ENTRIES-1:0] valid_q;
   logic [LPN_W-1:0]   lpn_a   [ENTRIES];
   logic [FRAME_W-1:0] frame_a [ENTRIES];
   logic [HPN_W-1:0]   host_a  [ENTRIES];
   logic [PERM_W-1:0]  perm_a  [ENTRIES];

   // Valid bits: a fill sets its entry even when a flush lands together.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (wr_en && (wr_idx == IDX_W'(e))) begin
               valid_q[e] <= 1'b1;
            end else if (inv_all) begin
               valid_q[e] <= 1'b0;
            end
         end
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic               sel;
      logic [LPN_W-1:0]   lpn_q;
      logic [FRAME_W-1:0] frame_q;
      logic [PERM_W-1:0]  perm_q;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (sel) begin
            lpn_q   <= wr_lpn;
            frame_q <= wr_frame;
            perm_q  <= wr_perm;
         end
      end

      assign lpn_a[e]   = lpn_q;
      assign frame_a[e] = frame_q;
      assign perm_a[e]  = perm_q;

      if (STORE_HOST) begin : g_host
         logic [HPN_W-1:0] host_q;
         always_ff @(posedge clk) begin
            if (sel) host_q <= wr_host;
         end
         assign host_a[e] = host_q;
      end else begin : g_no_host
         assign host_a[e] = '0;
      end
   end

   if (!STORE_HOST) begin : g_host_unused
      logic unused_host;
      assign unused_host = ^wr_host;
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_lpn   = lpn_a[rd_idx];
   assign rd_frame = frame_a[rd_idx];
   assign rd_host  = host_a[rd_idx];
   assign rd_perm  = perm_a[rd_idx];

endmodule

// File: rtl/xlat_resp_stage.sv
`timescale 1ns/1ps
module xlat_resp_stage #(
   parameter int LPN_W     = 20,
   parameter int FRAME_W   = 20,
   parameter int HPN_W     = 20,
   parameter int PAGE_BITS = 12,
   parameter int PERM_W    = 8,
   localparam int PSEL_W   = $clog2(PERM_W)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [LPN_W-1:0]             lpn,
   input  logic [PAGE_BITS-1:0]         offset,
   input  logic                         misalign,
   input  logic                         need_wr,
   input  logic [PSEL_W-1:0]            perm_sel,
   input  logic                         e_valid,
   input  logic [LPN_W-1:0]             e_lpn,
   input  logic [FRAME_W-1:0]           e_frame,
   input  logic [HPN_W-1:0]             e_host,
   input  logic [PERM_W-1:0]            e_perm,
   output logic                         rsp_valid,
   output logic                         rsp_hit,
   output logic [FRAME_W+PAGE_BITS-1:0] rsp_paddr,
   output logic [HPN_W+PAGE_BITS-1:0]   rsp_host,
   output logic                         wnote_valid,
   output logic [FRAME_W-1:0]           wnote_frame
);
   logic tag_ok;
   logic perm_ok;
   logic hit;

   assign tag_ok  = e_valid && (e_lpn == lpn) && !misalign;
   assign perm_ok = e_perm[perm_sel];
   assign hit     = req_valid && tag_ok && perm_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_paddr   <= '0;
         rsp_host    <= '0;
         wnote_valid <= 1'b0;
         wnote_frame <= '0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_hit     <= hit;
         wnote_valid <= hit && need_wr;
         if (req_valid) begin
            rsp_paddr   <= {e_frame, offset};
            rsp_host    <= {e_host, offset};
            wnote_frame <= e_frame;
         end
      end
   end

endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache #(
   parameter int LADDR_W    = 32,
   parameter int PAGE_BITS  = 12,
   parameter int FRAME_W    = 20,
   parameter int HPN_W      = 20,
   parameter int ENTRIES    = 16,
   parameter int NUM_PL     = 4,
   parameter bit STORE_HOST = 1'b1,
   localparam int LPN_W     = LADDR_W - PAGE_BITS,
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int PERM_W    = 2 * NUM_PL,
   localparam int PSEL_W    = $clog2(PERM_W),
   localparam int CPL_W     = $clog2(NUM_PL)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [LADDR_W-1:0]           req_laddr,
   input  logic [1:0]                   req_size,
   input  logic [1:0]                   req_kind,
   input  logic [CPL_W-1:0]             req_cpl,
   input  logic                         fill_valid,
   input  logic [LPN_W-1:0]             fill_lpage,
   input  logic [FRAME_W-1:0]           fill_frame,
   input  logic [HPN_W-1:0]             fill_host,
   input  logic [PERM_W-1:0]            fill_perm,
   input  logic                         inv_all,
   output logic                         rsp_valid,
   output logic                         rsp_hit,
   output logic [FRAME_W+PAGE_BITS-1:0] rsp_paddr,
   output logic [HPN_W+PAGE_BITS-1:0]   rsp_host,
   output logic                         wnote_valid,
   output logic [FRAME_W-1:0]           wnote_frame
);
   if ((ENTRIES < 2) || ((ENTRIES & (ENTRIES - 1)) != 0)) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be a power of two, at least 2");
   end
   if ((PAGE_BITS < 3) || (LADDR_W <= PAGE_BITS + IDX_W)) begin : g_bad_page
      $error("xlat_cache: PAGE_BITS must be >= 3 and leave room for the index");
   end
   if ((NUM_PL < 2) || ((NUM_PL & (NUM_PL - 1)) != 0)) begin : g_bad_pl
      $error("xlat_cache: NUM_PL must be a power of two, at least 2");
   end

   logic [IDX_W-1:0]     set_idx;
   logic [LPN_W-1:0]     req_lpn;
   logic [PAGE_BITS-1:0] req_off;
   logic                 misalign;
   logic                 need_wr;
   logic [PSEL_W-1:0]    perm_sel;

   logic                 e_valid;
   logic [LPN_W-1:0]     e_lpn;
   logic [FRAME_W-1:0]   e_frame;
   logic [HPN_W-1:0]     e_host;
   logic [PERM_W-1:0]    e_perm;

   xlat_req_decode #(
      .LADDR_W   (LADDR_W),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W),
      .NUM_PL    (NUM_PL)
   ) u_decode (
      .laddr    (req_laddr),
      .size     (req_size),
      .kind     (req_kind),
      .cpl      (req_cpl),
      .set_idx  (set_idx),
      .lpn      (req_lpn),
      .offset   (req_off),
      .misalign (misalign),
      .need_wr  (need_wr),
      .perm_sel (perm_sel)
   );

   xlat_entry_store #(
      .ENTRIES    (ENTRIES),
      .LPN_W      (LPN_W),
      .FRAME_W    (FRAME_W),
      .HPN_W      (HPN_W),
      .PERM_W     (PERM_W),
      .STORE_HOST (STORE_HOST)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .inv_all  (inv_all),
      .wr_en    (fill_valid),
      .wr_idx   (fill_lpage[IDX_W-1:0]),
      .wr_lpn   (fill_lpage),
      .wr_frame (fill_frame),
      .wr_host  (fill_host),
      .wr_perm  (fill_perm),
      .rd_idx   (set_idx),
      .rd_valid (e_valid),
      .rd_lpn   (e_lpn),
      .rd_frame (e_frame),
      .rd_host  (e_host),
      .rd_perm  (e_perm)
   );

   xlat_resp_stage #(
      .LPN_W     (LPN_W),
      .FRAME_W   (FRAME_W),
      .HPN_W     (HPN_W),
      .PAGE_BITS (PAGE_BITS),
      .PERM_W    (PERM_W)
   ) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .lpn         (req_lpn),
      .offset      (req_off),
      .misalign    (misalign),
      .need_wr     (need_wr),
      .perm_sel    (perm_sel),
      .e_valid     (e_valid),
      .e_lpn       (e_lpn),
      .e_frame     (e_frame),
      .e_host      (e_host),
      .e_perm      (e_perm),
      .rsp_valid   (rsp_valid),
      .rsp_hit     (rsp_hit),
      .rsp_paddr   (rsp_paddr),
      .rsp_host    (rsp_host),
      .wnote_valid (wnote_valid),
      .wnote_frame (wnote_frame)
   );

endmodule

// File: rtl/xlat_cache_checker.sv
`timescale 1ns/1ps
module xlat_cache_checker #(
   parameter int PAGE_BITS = 12,
   parameter int FRAME_W   = 20
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_valid,
   input logic [PAGE_BITS-1:0]         req_off,
   input logic [1:0]                   req_size,
   input logic [1:0]                   req_kind,
   input logic                         fill_valid,
   input logic                         inv_all,
   input logic                         rsp_valid,
   input logic                         rsp_hit,
   input logic [FRAME_W+PAGE_BITS-1:0] rsp_paddr,
   input logic                         wnote_valid,
   input logic [FRAME_W-1:0]           wnote_frame
);
   logic unaligned_c;
   logic flushed_q;

   assign unaligned_c = (4'(req_off[2:0]) & ((4'd1 << req_size) - 4'd1)) != 4'd0;

   always_ff @(posedge clk) begin
      if (!rst_n) flushed_q <= 1'b0;
      else        flushed_q <= inv_all && !fill_valid;
   end

   a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r1_hit_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == $past(req_off));

   a_r6_unaligned_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && unaligned_c) |=> !rsp_hit);

   a_r8_note_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      wnote_valid |-> (rsp_hit && wnote_frame == rsp_paddr[FRAME_W+PAGE_BITS-1:PAGE_BITS]));

   a_r8_read_no_note: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd0) |=> !wnote_valid);

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (flushed_q && req_valid) |=> !rsp_hit);

endmodule

bind xlat_cache xlat_cache_checker #(
   .PAGE_BITS (PAGE_BITS),
   .FRAME_W   (FRAME_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_off     (req_laddr[PAGE_BITS-1:0]),
   .req_size    (req_size),
   .req_kind    (req_kind),
   .fill_valid  (fill_valid),
   .inv_all     (inv_all),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .rsp_paddr   (rsp_paddr),
   .wnote_valid (wnote_valid),
   .wnote_frame (wnote_frame)
);

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;
   localparam int LA = 32;
   localparam int PB = 12;
   localparam int FW = 20;
   localparam int HW = 20;
   localparam int NE = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [LA-1:0] req_laddr;
   logic [1:0]    req_size;
   logic [1:0]    req_kind;
   logic [1:0]    req_cpl;
   logic          fill_valid;
   logic [LA-PB-1:0] fill_lpage;
   logic [FW-1:0] fill_frame;
   logic [HW-1:0] fill_host;
   logic [7:0]    fill_perm;
   logic          inv_all;
   logic          rsp_valid;
   logic          rsp_hit;
   logic [FW+PB-1:0] rsp_paddr;
   logic [HW+PB-1:0] rsp_host;
   logic          wnote_valid;
   logic [FW-1:0] wnote_frame;

   always #4 clk = ~clk;

   xlat_cache #(.LADDR_W(LA), .PAGE_BITS(PB), .FRAME_W(FW), .HPN_W(HW), .ENTRIES(NE)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
      .req_size(req_size), .req_kind(req_kind), .req_cpl(req_cpl),
      .fill_valid(fill_valid), .fill_lpage(fill_lpage), .fill_frame(fill_frame),
      .fill_host(fill_host), .fill_perm(fill_perm), .inv_all(inv_all),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
      .rsp_host(rsp_host), .wnote_valid(wnote_valid), .wnote_frame(wnote_frame)
   );

   typedef struct {
      logic        hit;
      logic [31:0] pa;
      logic [31:0] ha;
      logic        note;
      logic [19:0] frame;
      int          cyc;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   cyc    = 0;
   int   checks = 0;
   int   errors = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Driver: push the expected response, present the request for one cycle.
   task automatic put_req(input logic [31:0] addr, input logic [1:0] size,
                          input logic [1:0] kind, input logic [1:0] cpl,
                          input logic hit, input logic [19:0] frame,
                          input logic [19:0] host, input string tag);
      exp_t e;
      e.hit   = hit;
      e.pa    = {frame, addr[11:0]};
      e.ha    = {host, addr[11:0]};
      e.note  = hit && (kind != 2'd0);
      e.frame = frame;
      e.cyc   = cyc;
      e.tag   = tag;
      q.push_back(e);
      req_valid = 1'b1;
      req_laddr = addr;
      req_size  = size;
      req_kind  = kind;
      req_cpl   = cpl;
   endtask

   task automatic lookup(input logic [31:0] addr, input logic [1:0] size,
                         input logic [1:0] kind, input logic [1:0] cpl,
                         input logic hit, input logic [19:0] frame,
                         input logic [19:0] host, input string tag);
      put_req(addr, size, kind, cpl, hit, frame, host, tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic put_fill(input logic [19:0] lpage, input logic [19:0] frame,
                           input logic [19:0] host, input logic [7:0] perm);
      fill_valid = 1'b1;
      fill_lpage = lpage;
      fill_frame = frame;
      fill_host  = host;
      fill_perm  = perm;
   endtask

   task automatic fill(input logic [19:0] lpage, input logic [19:0] frame,
                       input logic [19:0] host, input logic [7:0] perm);
      put_fill(lpage, frame, host, perm);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // Monitor: compare each response against the head of the queue.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R1 unexpected response: rsp_valid=1 expected 0");
            end else begin
               exp_t e;
               logic bad;
               e = q.pop_front();
               bad = (cyc != e.cyc + 1) || (rsp_hit !== e.hit) || (wnote_valid !== e.note);
               if (e.hit && ((rsp_paddr !== e.pa) || (rsp_host !== e.ha))) bad = 1'b1;
               if (e.note && (wnote_frame !== e.frame)) bad = 1'b1;
               if (bad) begin
                  errors++;
                  $display("FAIL %s: cyc=%0d hit=%0b pa=%h host=%h note=%0b frame=%h expected cyc=%0d hit=%0b pa=%h host=%h note=%0b frame=%h",
                           e.tag, cyc, rsp_hit, rsp_paddr, rsp_host, wnote_valid, wnote_frame,
                           e.cyc + 1, e.hit, e.pa, e.ha, e.note, e.frame);
               end
            end
         end else if (wnote_valid || rsp_hit) begin
            checks++;
            errors++;
            $display("FAIL R1 output without response: hit=%0b note=%0b expected 0 0",
                     rsp_hit, wnote_valid);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc == 20000) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog expired: cyc=%0d expected < 20000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_laddr = '0; req_size = '0; req_kind = '0; req_cpl = '0;
      fill_valid = 1'b0; fill_lpage = '0; fill_frame = '0; fill_host = '0; fill_perm = '0;
      inv_all = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || wnote_valid !== 1'b0) begin
         errors++;
         $display("FAIL R5 reset state: valid=%0b hit=%0b note=%0b expected 0 0 0",
                  rsp_valid, rsp_hit, wnote_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);

      lookup(32'h0001_2345, 2'd2, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R5 empty after reset");

      // Page 0x12 -> set 2; read at levels 0,1, write at level 0.
      fill(20'h00012, 20'hABCDE, 20'h80000, 8'h13);
      lookup(32'h0001_2344, 2'd2, 2'd0, 2'd0, 1'b1, 20'hABCDE, 20'h80000, "R2 R3 read hit");
      lookup(32'h0001_2FFF, 2'd0, 2'd0, 2'd1, 1'b1, 20'hABCDE, 20'h80000, "R3 read level1 last byte");
      lookup(32'h0001_2000, 2'd0, 2'd0, 2'd2, 1'b0, 20'h0, 20'h0, "R3 read level2 no bit");
      lookup(32'h0001_2008, 2'd3, 2'd1, 2'd0, 1'b1, 20'hABCDE, 20'h80000, "R4 R8 write hit");
      lookup(32'h0001_2010, 2'd2, 2'd1, 2'd1, 1'b0, 20'h0, 20'h0, "R4 write level1 no bit");
      lookup(32'h0001_2010, 2'd2, 2'd2, 2'd1, 1'b0, 20'h0, 20'h0, "R4 rmw ignores read bit");
      lookup(32'h0001_2002, 2'd1, 2'd2, 2'd0, 1'b1, 20'hABCDE, 20'h80000, "R4 R8 rmw hit");
      lookup(32'h0001_2020, 2'd2, 2'd3, 2'd0, 1'b1, 20'hABCDE, 20'h80000, "R4 kind3 as rmw");
      lookup(32'h0001_2002, 2'd2, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R6 unaligned in page");
      lookup(32'h0001_2FFF, 2'd1, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R6 two-byte crossing");

      // Page 0x13 -> set 3, all permissions.
      fill(20'h00013, 20'h11111, 20'h22222, 8'hFF);
      lookup(32'h0001_2FFC, 2'd3, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R6 R7 crossing into filled set");
      lookup(32'h0001_3FF8, 2'd3, 2'd0, 2'd3, 1'b1, 20'h11111, 20'h22222, "R3 R7 level3 read");
      lookup(32'h0001_6000, 2'd0, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R5 tag mismatch");

      // Page 0x16 aliases page 0x12 in set 2: write-only at level 0.
      fill(20'h00016, 20'h33333, 20'h00777, 8'h10);
      lookup(32'h0001_2000, 2'd0, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R7 evicted by alias");
      lookup(32'h0001_6000, 2'd0, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R3 write-only page read");
      lookup(32'h0001_6010, 2'd2, 2'd1, 2'd0, 1'b1, 20'h33333, 20'h00777, "R8 write hit new frame");

      // Fill page 0x17 into set 3 while looking up page 0x13 there.
      put_fill(20'h00017, 20'h44444, 20'h55555, 8'h01);
      put_req(32'h0001_3000, 2'd0, 2'd0, 2'd0, 1'b1, 20'h11111, 20'h22222, "R10 lookup sees old entry");
      @(negedge clk);
      fill_valid = 1'b0;
      req_valid  = 1'b0;
      lookup(32'h0001_3000, 2'd0, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R10 old page gone");
      lookup(32'h0001_7000, 2'd0, 2'd0, 2'd0, 1'b1, 20'h44444, 20'h55555, "R10 new page present");

      // Flush everything.
      inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      lookup(32'h0001_6010, 2'd2, 2'd1, 2'd0, 1'b0, 20'h0, 20'h0, "R9 flushed set2");
      lookup(32'h0001_7000, 2'd0, 2'd0, 2'd0, 1'b0, 20'h0, 20'h0, "R9 flushed set3");

      // Flush and fill together: the fill survives.
      inv_all = 1'b1;
      put_fill(20'h00017, 20'h66666, 20'h12345, 8'h01);
      @(negedge clk);
      inv_all    = 1'b0;
      fill_valid = 1'b0;
      lookup(32'h0001_7004, 2'd2, 2'd0, 2'd0, 1'b1, 20'h66666, 20'h12345, "R9 fill beats flush");

      repeat (4) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R1 missing responses: pending=%0d expected 0", q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule